// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside the instruction engine of a small 8-bit processor. It turns a pending interrupt request into an automatic call into the interrupt table, and it turns a return-from-interrupt opcode back into a resumed program. It waits for the current instruction to finish before it accepts a request. It then runs a fixed 13-cycle entry. During entry it saves the program counter and the flag byte on a byte-wide stack, clears the flags so that the global interrupt enable drops, and loads the program counter with `0x00` in the high byte and the controller's vector in the low byte.

For a return, the sequencer pops the saved context in the reverse order and hands the restored program counter and flags back to the engine. If another request is already waiting and the restored flags re-enable interrupts, the next entry starts in the cycle right after the return. No normal instruction runs in between.

The engine owns the program counter and flag registers. It presents their current values on `pc_in` / `flags_in` and applies the write strobes that this block issues. The stack memory is read asynchronously at `stk_addr`. While `busy` is high the engine stays stalled.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is accepted only in a cycle where the sequencer is idle, `irq_pending` and `instr_done` are both high, and the global-enable bit of `flags_in` (bit 0 by default) is 1. A request is ignored in any other cycle, and an ignored request leaves `busy`, `sp` and every strobe unchanged.
- R2: After acceptance, `busy` is high for exactly 13 consecutive cycles, beginning in the cycle after the accepting clock edge.
- R3: In entry cycles 1, 2 and 3, `stk_we` pushes PC[15:8], then PC[7:0], then the flag byte captured at acceptance. Each push writes to address `sp`, and `sp` increments after each push.
- R4: In entry cycle 4, `flag_wr` writes `0x00` to the flags, which clears the global enable.
- R5: In entry cycle 13, `irq_ack` is high for that single cycle, `irq_vector` is sampled in that cycle, and `pc_wr` writes `{0x00, irq_vector}`.
- R6: When the sequencer is idle and `op_valid` is high with `op_code == 0x7E`, a 3-cycle return starts. The return pops the flags, then PC[7:0], then PC[15:8]. Each pop first decrements `sp` and reads at the decremented address. The third cycle writes the restored PC via `pc_wr` and the restored flags via `flag_wr`.
- R7: Chaining: if, in the third return cycle, `irq_pending` is high and the restored flags have the global-enable bit set, a new entry begins in the next cycle with no idle cycle between. That entry pushes the restored PC and flags.
- R8: If an acceptable request and a return opcode appear in the same idle cycle, the interrupt is accepted and the opcode is ignored.
- R9: After reset, `sp` is 0, `busy` is low and no strobe is asserted.
- R10: `stk_we` and `stk_re` are never high together. No strobe (`stk_we`, `stk_re`, `pc_wr`, `flag_wr`, `irq_ack`) is asserted while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pending | input | 1 | Interrupt controller has a request waiting |
| instr_done | input | 1 | Current instruction completes in this cycle |
| op_valid | input | 1 | An opcode is presented for execution |
| op_code | input | 8 | Opcode being executed (return is 0x7E) |
| irq_ack | output | 1 | Acknowledge to the controller; vector sampled this cycle |
| irq_vector | input | 8 | Vector from the interrupt controller |
| pc_in | input | 16 | Current program counter of the engine |
| flags_in | input | 8 | Current flag byte of the engine |
| pc_wr | output | 1 | Program counter write strobe |
| pc_wdata | output | 16 | Program counter write value |
| flag_wr | output | 1 | Flag byte write strobe |
| flag_wdata | output | 8 | Flag byte write value |
| stk_we | output | 1 | Stack memory write strobe |
| stk_re | output | 1 | Stack memory read strobe |
| stk_addr | output | 8 | Stack memory address |
| stk_wdata | output | 8 | Stack memory write data |
| stk_rdata | input | 8 | Stack memory read data (combinational) |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | Sequencer active; engine must stall |

## Verification
The checker covers the local rules on every cycle:
- A push increments the stack pointer.
- A pop addresses one below it and then decrements it.
- Reads and writes never coincide.
- Nothing strobes while idle.
- The flag write right after the last push is zero.
- The acknowledge coincides with a program counter load whose high byte is zero.
- Each new entry (one that follows an idle cycle) was gated by boundary, request and enable, and its first push is the old high PC byte.

The bench scenarios are the only way to show the properties that span a whole sequence:
- The exact 13-cycle length.
- The full push and pop byte order, including nested entries.
- Precedence of an interrupt over a simultaneous return.
- The chained entry after a return, with no idle cycle between.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_ENTRY = 2'd1,
      SEQ_RET   = 2'd2
   } seq_state_e;

   // Number of bytes saved on the stack per interrupt: PC high, PC low, flags
   localparam int CTX_BYTES = 3;

endpackage

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
   import irq_seq_pkg::*;
#(
   parameter int ENTRY_CYC = 13,
   parameter int RET_CYC   = 3,
   parameter int CNT_W     = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_entry,
   input  logic       start_ret,
   input  logic       chain,
   output seq_state_e state,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] E_LAST = CNT_W'(ENTRY_CYC - 1);
   localparam logic [CNT_W-1:0] R_LAST = CNT_W'(RET_CYC - 1);

   generate
      if ((1 << CNT_W) < ENTRY_CYC || (1 << CNT_W) < RET_CYC) begin : g_bad_cnt
         $error("irq_seq_fsm: CNT_W too narrow for sequence length");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            SEQ_IDLE: begin
               cnt <= '0;
               if (start_entry)    state <= SEQ_ENTRY;
               else if (start_ret) state <= SEQ_RET;
            end
            SEQ_ENTRY: begin
               if (cnt == E_LAST) begin
                  state <= SEQ_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            SEQ_RET: begin
               if (cnt == R_LAST) begin
                  state <= chain ? SEQ_ENTRY : SEQ_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               state <= SEQ_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

endmodule

// File: rtl/irq_seq_stack.sv
module irq_seq_stack #(
   parameter int SP_W   = 8,
   parameter int SP_RST = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  logic            pop,
   output logic [SP_W-1:0] sp,
   output logic [SP_W-1:0] addr
);

   localparam logic [SP_W-1:0] ONE    = SP_W'(1);
   localparam logic [SP_W-1:0] SP_INI = SP_W'(SP_RST);

   generate
      if (SP_W < 2) begin : g_bad_sp
         $error("irq_seq_stack: SP_W must be at least 2");
      end
   endgenerate

   // Pops pre-decrement: the address seen by memory is one below sp
   assign addr = pop ? (sp - ONE) : sp;

   always_ff @(posedge clk) begin
      if (!rst_n)    sp <= SP_INI;
      else if (push) sp <= sp + ONE;
      else if (pop)  sp <= sp - ONE;
   end

endmodule

// File: rtl/irq_seq_ctx.sv
module irq_seq_ctx #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_live,
   input  logic          cap_chain,
   input  logic [2*DW-1:0] pc_live,
   input  logic [DW-1:0] fl_live,
   input  logic          pop_flg,
   input  logic          pop_pcl,
   input  logic [DW-1:0] rdata,
   output logic [2*DW-1:0] ctx_pc,
   output logic [DW-1:0] ctx_fl,
   output logic [DW-1:0] pcl_q,
   output logic [DW-1:0] flg_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctx_pc <= '0;
         ctx_fl <= '0;
      end else if (cap_live) begin
         ctx_pc <= pc_live;
         ctx_fl <= fl_live;
      end else if (cap_chain) begin
         // Context for a chained entry is the one just popped
         ctx_pc <= {rdata, pcl_q};
         ctx_fl <= flg_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pcl_q <= '0;
         flg_q <= '0;
      end else begin
         if (pop_flg) flg_q <= rdata;
         if (pop_pcl) pcl_q <= rdata;
      end
   end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_seq_pkg::*;
#(
   parameter int           DW        = 8,
   parameter int           OPC_W     = 8,
   parameter int           SP_W      = 8,
   parameter int           ENTRY_CYC = 13,
   parameter int           GIE_BIT   = 0,
   parameter int           SP_RST    = 0,
   parameter logic [7:0]   RETI_OPC  = 8'h7E
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            irq_pending,
   input  logic            instr_done,
   input  logic            op_valid,
   input  logic [OPC_W-1:0] op_code,
   output logic            irq_ack,
   input  logic [DW-1:0]   irq_vector,
   input  logic [2*DW-1:0] pc_in,
   input  logic [DW-1:0]   flags_in,
   output logic            pc_wr,
   output logic [2*DW-1:0] pc_wdata,
   output logic            flag_wr,
   output logic [DW-1:0]   flag_wdata,
   output logic            stk_we,
   output logic            stk_re,
   output logic [SP_W-1:0] stk_addr,
   output logic [DW-1:0]   stk_wdata,
   input  logic [DW-1:0]   stk_rdata,
   output logic [SP_W-1:0] sp,
   output logic            busy
);

   localparam int PC_W    = 2 * DW;
   localparam int RET_CYC = CTX_BYTES;
   localparam int CNT_W   = $clog2(ENTRY_CYC);

   localparam logic [CNT_W-1:0] C_PUSH_END = CNT_W'(CTX_BYTES);
   localparam logic [CNT_W-1:0] C_CLR      = CNT_W'(CTX_BYTES);
   localparam logic [CNT_W-1:0] C_ACK      = CNT_W'(ENTRY_CYC - 1);
   localparam logic [CNT_W-1:0] C_POP_FL   = CNT_W'(0);
   localparam logic [CNT_W-1:0] C_POP_PCL  = CNT_W'(1);
   localparam logic [CNT_W-1:0] C_POP_LAST = CNT_W'(RET_CYC - 1);
   localparam logic [OPC_W-1:0] RET_OP     = OPC_W'(RETI_OPC);

   generate
      if (ENTRY_CYC < CTX_BYTES + 2) begin : g_bad_len
         $error("irq_entry_seq: entry too short for push, clear and vector");
      end
      if (GIE_BIT < 0 || GIE_BIT >= DW) begin : g_bad_gie
         $error("irq_entry_seq: GIE_BIT outside flag byte");
      end
   endgenerate

   seq_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic             in_idle, in_entry, in_ret;
   logic             accept, ret_go, chain;
   logic             push, pop, ret_last;
   logic [PC_W-1:0]  ctx_pc;
   logic [DW-1:0]    ctx_fl, pcl_q, flg_q;

   assign in_idle  = (state == SEQ_IDLE);
   assign in_entry = (state == SEQ_ENTRY);
   assign in_ret   = (state == SEQ_RET);

   // Interrupt acceptance wins over a return opcode in the same cycle
   assign accept   = in_idle && irq_pending && instr_done && flags_in[GIE_BIT];
   assign ret_go   = in_idle && !accept && op_valid && (op_code == RET_OP);
   assign ret_last = in_ret && (cnt == C_POP_LAST);
   assign chain    = ret_last && irq_pending && flg_q[GIE_BIT];

   assign push = in_entry && (cnt < C_PUSH_END);
   assign pop  = in_ret;

   irq_seq_fsm #(
      .ENTRY_CYC (ENTRY_CYC),
      .RET_CYC   (RET_CYC),
      .CNT_W     (CNT_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_entry (accept),
      .start_ret   (ret_go),
      .chain       (chain),
      .state       (state),
      .cnt         (cnt)
   );

   irq_seq_stack #(
      .SP_W   (SP_W),
      .SP_RST (SP_RST)
   ) u_stack (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .pop   (pop),
      .sp    (sp),
      .addr  (stk_addr)
   );

   irq_seq_ctx #(
      .DW (DW)
   ) u_ctx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_live  (accept),
      .cap_chain (chain),
      .pc_live   (pc_in),
      .fl_live   (flags_in),
      .pop_flg   (in_ret && (cnt == C_POP_FL)),
      .pop_pcl   (in_ret && (cnt == C_POP_PCL)),
      .rdata     (stk_rdata),
      .ctx_pc    (ctx_pc),
      .ctx_fl    (ctx_fl),
      .pcl_q     (pcl_q),
      .flg_q     (flg_q)
   );

   always_comb begin
      unique case (cnt)
         CNT_W'(0): stk_wdata = ctx_pc[PC_W-1:DW];
         CNT_W'(1): stk_wdata = ctx_pc[DW-1:0];
         default:   stk_wdata = ctx_fl;
      endcase
   end

   assign stk_we     = push;
   assign stk_re     = pop;
   assign irq_ack    = in_entry && (cnt == C_ACK);
   assign pc_wr      = irq_ack || ret_last;
   assign pc_wdata   = in_ret ? {stk_rdata, pcl_q} : {{DW{1'b0}}, irq_vector};
   assign flag_wr    = (in_entry && (cnt == C_CLR)) || ret_last;
   assign flag_wdata = in_ret ? flg_q : '0;
   assign busy       = !in_idle;

endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
   parameter int DW      = 8,
   parameter int SP_W    = 8,
   parameter int GIE_BIT = 0
) (
   input logic            clk,
   input logic            rst_n,
   input logic            irq_pending,
   input logic            instr_done,
   input logic [DW-1:0]   flags_in,
   input logic [DW-1:0]   pc_hi,
   input logic            irq_ack,
   input logic            pc_wr,
   input logic [2*DW-1:0] pc_wdata,
   input logic            flag_wr,
   input logic [DW-1:0]   flag_wdata,
   input logic            stk_we,
   input logic            stk_re,
   input logic [SP_W-1:0] stk_addr,
   input logic [DW-1:0]   stk_wdata,
   input logic [SP_W-1:0] sp,
   input logic            busy
);

   AST_ENTRY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && stk_we) |-> $past(instr_done && irq_pending && flags_in[GIE_BIT])); // R1

   AST_FIRST_PUSH_PCH: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && stk_we) |-> (stk_wdata == $past(pc_hi))); // R3

   AST_PUSH_INC: assert property (@(posedge clk) disable iff (!rst_n)
      stk_we |=> (sp == $past(sp) + SP_W'(1))); // R3

   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && $past(stk_we)) |-> (flag_wdata == '0)); // R4

   AST_ACK_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> (busy && pc_wr && (pc_wdata[2*DW-1:DW] == '0))); // R5

   AST_POP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      stk_re |-> (stk_addr == sp - SP_W'(1))); // R6

   AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      stk_re |=> (sp == $past(sp) - SP_W'(1))); // R6

   AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
      !(stk_we && stk_re)); // R10

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(stk_we || stk_re || pc_wr || flag_wr || irq_ack)); // R10

endmodule

bind irq_entry_seq irq_seq_chk #(
   .DW      (DW),
   .SP_W    (SP_W),
   .GIE_BIT (GIE_BIT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .irq_pending (irq_pending),
   .instr_done  (instr_done),
   .flags_in    (flags_in),
   .pc_hi       (pc_in[2*DW-1:DW]),
   .irq_ack     (irq_ack),
   .pc_wr       (pc_wr),
   .pc_wdata    (pc_wdata),
   .flag_wr     (flag_wr),
   .flag_wdata  (flag_wdata),
   .stk_we      (stk_we),
   .stk_re      (stk_re),
   .stk_addr    (stk_addr),
   .stk_wdata   (stk_wdata),
   .sp          (sp),
   .busy        (busy)
);

// File: tb/tb_irq_entry_seq.sv
`timescale 1ns/1ps
module tb_irq_entry_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pend = 1'b0, done = 1'b0, opv = 1'b0;
   logic [7:0]  opc = 8'h00, vec = 8'h00;
   logic        irq_ack, pc_wr, flag_wr, stk_we, stk_re, busy;
   logic [15:0] pc_wdata;
   logic [7:0]  flag_wdata, stk_addr, stk_wdata, sp;
   logic [15:0] pc_r;
   logic [7:0]  fl_r;
   logic [7:0]  mem [0:255];
   logic        sw_req = 1'b0;
   logic [7:0]  sw_val = 8'h00;
   int nchk = 0, nerr = 0;
   bit fin = 0;

   always #2.5 clk = ~clk;

   irq_entry_seq dut (
      .clk(clk), .rst_n(rst_n), .irq_pending(pend), .instr_done(done),
      .op_valid(opv), .op_code(opc), .irq_ack(irq_ack), .irq_vector(vec),
      .pc_in(pc_r), .flags_in(fl_r), .pc_wr(pc_wr), .pc_wdata(pc_wdata),
      .flag_wr(flag_wr), .flag_wdata(flag_wdata), .stk_we(stk_we),
      .stk_re(stk_re), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
      .stk_rdata(mem[stk_addr]), .sp(sp), .busy(busy)
   );

   // Engine and stack memory modelled in the bench
   always @(posedge clk) begin
      if (!rst_n) begin
         pc_r <= 16'h1234;
         fl_r <= 8'h01;
      end else begin
         if (pc_wr) pc_r <= pc_wdata;
         if (flag_wr) fl_r <= flag_wdata;
         else if (sw_req) fl_r <= sw_val;
         if (stk_we) mem[stk_addr] <= stk_wdata;
      end
   end

   task automatic ceq(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Behavioural reference: mode 0 idle, 1 entry, 2 return; k = step
   int m_mode, m_k, m_sp, m_pc, m_f, m_pcl, m_flg;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_k = 0; m_sp = 0;
      end else begin
         case (m_mode)
            0: begin
               if (pend && done && fl_r[0]) begin
                  m_mode = 1; m_k = 0; m_pc = pc_r; m_f = fl_r;
               end else if (opv && opc == 8'h7E) begin
                  m_mode = 2; m_k = 0;
               end
            end
            1: begin
               if (m_k < 3) m_sp = (m_sp + 1) & 255;
               if (m_k == 12) m_mode = 0; else m_k++;
            end
            default: begin
               int rd;
               rd = mem[(m_sp - 1) & 255];
               m_sp = (m_sp - 1) & 255;
               if (m_k == 0) m_flg = rd;
               if (m_k == 1) m_pcl = rd;
               if (m_k == 2) begin
                  if (pend && m_flg[0]) begin
                     m_mode = 1; m_k = 0; m_pc = (rd << 8) | m_pcl; m_f = m_flg;
                  end else m_mode = 0;
               end else m_k++;
            end
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n && !fin) begin
         bit e_we, e_re, e_ack, e_pcw, e_flw;
         e_we  = (m_mode == 1) && (m_k < 3);
         e_re  = (m_mode == 2);
         e_ack = (m_mode == 1) && (m_k == 12);
         e_pcw = e_ack || ((m_mode == 2) && (m_k == 2));
         e_flw = ((m_mode == 1) && (m_k == 3)) || ((m_mode == 2) && (m_k == 2));
         ceq("R2 busy per cycle", busy, m_mode != 0);
         ceq("R3 stk_we per cycle", stk_we, e_we);
         ceq("R6 stk_re per cycle", stk_re, e_re);
         ceq("R10 no strobe clash", stk_we && stk_re, 0);
         ceq("R3 sp per cycle", sp, m_sp);
         ceq("R5 irq_ack per cycle", irq_ack, e_ack);
         ceq("R5 pc_wr per cycle", pc_wr, e_pcw);
         ceq("R4 flag_wr per cycle", flag_wr, e_flw);
         if (e_we) begin
            ceq("R3 push addr", stk_addr, m_sp);
            ceq("R3 push data", stk_wdata,
                m_k == 0 ? (m_pc >> 8) & 255 : m_k == 1 ? m_pc & 255 : m_f);
         end
         if (e_re) ceq("R6 pop addr", stk_addr, (m_sp - 1) & 255);
         if (e_flw) ceq("R4 flag data", flag_wdata, m_mode == 1 ? 0 : m_flg);
         if (e_pcw) ceq("R5 pc data", pc_wdata, m_mode == 1 ? vec :
                        (mem[(m_sp - 1) & 255] << 8) | m_pcl);
      end
   end

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
   endtask

   task automatic set_flags(input logic [7:0] v);
      sw_req = 1'b1; sw_val = v; tick(); sw_req = 1'b0;
   endtask

   // Returns number of consecutive busy cycles seen from the next negedge
   task automatic count_busy(output int n);
      n = 0;
      @(negedge clk);
      while (busy && n < 100) begin n++; @(negedge clk); end
      @(posedge clk); #1;
   endtask

   task automatic irq(input logic [7:0] v, input bit with_ret, output int n);
      vec = v; pend = 1'b1; done = 1'b1;
      if (with_ret) begin opv = 1'b1; opc = 8'h7E; end
      @(posedge clk); #1;
      pend = 1'b0; done = 1'b0; opv = 1'b0;
      count_busy(n);
   endtask

   task automatic reti(input bit keep_pend, input logic [7:0] v, output int n);
      vec = v; pend = keep_pend; opv = 1'b1; opc = 8'h7E;
      @(posedge clk); #1;
      opv = 1'b0;
      count_busy(n);
      pend = 1'b0;
   endtask

   initial begin
      #(5.0 * 200000);
      if (!fin) begin
         nerr++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      int n;
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      tick(3);
      rst_n = 1'b1;
      @(negedge clk);
      ceq("R9 reset busy", busy, 0);
      ceq("R9 reset sp", sp, 0);
      ceq("R9 reset strobes", {stk_we, stk_re, pc_wr, flag_wr, irq_ack}, 0);
      tick();

      // R1: global enable clear -> request ignored
      set_flags(8'h00);
      pend = 1'b1; done = 1'b1; tick(5);
      ceq("R1 ignored without enable busy", busy, 0);
      ceq("R1 ignored without enable sp", sp, 0);
      pend = 1'b0; done = 1'b0;
      set_flags(8'h01);
      // R1: no instruction boundary -> request held off
      pend = 1'b1; tick(4);
      ceq("R1 held until boundary", busy, 0);
      pend = 1'b0;

      // R2..R5: plain entry
      irq(8'h0C, 1'b0, n);
      ceq("R2 entry length", n, 13);
      ceq("R5 pc after entry", pc_r, 16'h000C);
      ceq("R4 flags cleared", fl_r, 8'h00);
      ceq("R3 push pch", mem[0], 8'h12);
      ceq("R3 push pcl", mem[1], 8'h34);
      ceq("R3 push flags", mem[2], 8'h01);
      ceq("R3 sp after entry", sp, 3);

      // Nested entry after handler re-enables
      set_flags(8'h01);
      irq(8'h20, 1'b0, n);
      ceq("R2 nested entry length", n, 13);
      ceq("R3 nested pch", mem[3], 8'h00);
      ceq("R3 nested pcl", mem[4], 8'h0C);
      ceq("R3 nested flags", mem[5], 8'h01);
      ceq("R5 nested pc", pc_r, 16'h0020);

      // R6: return from nested
      reti(1'b0, 8'h00, n);
      ceq("R6 return length", n, 3);
      ceq("R6 pc restored", pc_r, 16'h000C);
      ceq("R6 flags restored", fl_r, 8'h01);
      ceq("R6 sp after return", sp, 3);

      // R8: interrupt wins over a simultaneous return opcode
      irq(8'h30, 1'b1, n);
      ceq("R8 entry taken", n, 13);
      ceq("R8 pc is vector", pc_r, 16'h0030);
      ceq("R8 sp", sp, 6);

      // R7: return with a waiting request chains straight into entry
      reti(1'b1, 8'h44, n);
      ceq("R7 chained busy length", n, 16);
      ceq("R7 chained pc", pc_r, 16'h0044);
      ceq("R7 chained flags", fl_r, 8'h00);
      ceq("R7 chained sp", sp, 6);
      ceq("R7 chained pcl pushed", mem[4], 8'h0C);

      reti(1'b0, 8'h00, n);
      ceq("R6 pc level 1", pc_r, 16'h000C);
      reti(1'b0, 8'h00, n);
      ceq("R6 pc level 0", pc_r, 16'h1234);
      ceq("R6 flags level 0", fl_r, 8'h01);
      ceq("R6 sp level 0", sp, 0);
      tick(2);
      ceq("R10 idle quiet", {stk_we, stk_re, pc_wr, flag_wr, irq_ack}, 0);

      fin = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule